// File: doc/BRIEF.md
# 100 Mb/s Receive Code-Group Decoder

This block sits behind the descrambler and symbol aligner of a 100 Mb/s copper receive path. Each cycle in which the aligner presents a 5-bit code-group, the block turns it into a 4-bit data nibble. It raises a receive error flag for code-groups that are invalid or that signal an error while a frame is in progress. It also keeps a 16-bit count of corrupted packets, which a management register reads.

A bypass control skips the decoder. The raw 5-bit symbol is then handed out unchanged for a MAC that works on symbols. All outputs are registered and appear one clock after the code-group is strobed in. A synchronous clear resets the error count without disturbing anything else.

Top module: `rx_symbol_decoder`

## Requirements
- R1: A strobed data code-group produces its nibble on `nib_out` and a high `out_valid` exactly one clock later. The mapping, nibble to code-group, is: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R2: The control code-groups 11111 (idle), 11000 and 10001 (start pair), 01101 and 00111 (end pair) produce nibble 0 and never raise `rx_err`.
- R3: A code-group that is neither data nor control is invalid. This covers 00010, 00011, 00101, 01000, 01100 and 10000, as well as 00000, 00001, 00110 and 11001. An invalid code-group strobed while `frame_active` is high raises `rx_err` in the output cycle and drives nibble 0.
- R4: An invalid code-group strobed while `frame_active` is low raises no `rx_err` and leaves `err_count` unchanged.
- R5: The transmit-error code-group 00100, strobed while `frame_active` is high, raises `rx_err` and drives nibble 0, and does not change `err_count`.
- R6: The first invalid code-group of a frame increments `err_count` by one, visible one clock later. Further invalid code-groups in the same frame leave it unchanged.
- R7: A cycle with `frame_active` low ends the frame. The first invalid code-group of the next frame counts again.
- R8: `err_count` wraps from 65535 to 0 on the next counted error.
- R9: `cnt_clear` high makes `err_count` zero one clock later, and it takes priority over an increment in the same cycle.
- R10: With `raw_mode` high, the strobed symbol appears on `raw_out`, with bit 4 as the most significant bit, and its low four bits appear on `nib_out`. `rx_err` stays low and `err_count` is unchanged even for invalid code-groups. With `raw_mode` low, `raw_out` is 0.
- R11: After reset, `out_valid`, `rx_err`, `nib_out`, `raw_out` and `err_count` are all zero.
- R12: A clock without `cg_valid` drives `out_valid` and `rx_err` low one clock later and holds `nib_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| cg_valid | input | 1 | Code-group strobe |
| cg_in | input | 5 | Aligned, descrambled code-group |
| frame_active | input | 1 | Receive data valid, high for the duration of a frame |
| raw_mode | input | 1 | Skip decoding and pass symbols through |
| cnt_clear | input | 1 | Synchronous clear of the error count |
| out_valid | output | 1 | Output cycle carries a new result |
| nib_out | output | 4 | Decoded nibble, or low four raw bits in bypass |
| raw_out | output | 5 | Raw symbol in bypass, zero otherwise |
| rx_err | output | 1 | Receive error for the current output cycle |
| err_count | output | 16 | Count of packets holding an invalid code-group |

## Verification
The bench walks all sixteen data code-groups, every control symbol and all ten invalid patterns. A decoder with a wrong table entry would therefore emit a wrong nibble or a spurious error. It sends several invalid symbols in a single frame, then closes the frame and opens a new one. A counter that counts every bad symbol, or whose per-frame flag never clears, would then drift from the expected count. Invalid and transmit-error symbols outside a frame, and in bypass, must neither flag nor count. A clear is asserted together with a counted error to expose wrong priority. The count is driven through 65535 to show that it wraps to 0 rather than sticking.

// File: rtl/sym_dec_pkg.sv
package sym_dec_pkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    K_DATA    = 2'd0,
    K_CTRL    = 2'd1,
    K_HALT    = 2'd2,
    K_INVALID = 2'd3
  } sym_kind_e;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    sym_kind_e        kind;
  } dec_t;

  function automatic dec_t decode_sym(input logic [SYM_W-1:0] s);
    dec_t d;
    d.nib  = '0;
    d.kind = K_DATA;
    case (s)
      5'b11110: d.nib = 4'h0;
      5'b01001: d.nib = 4'h1;
      5'b10100: d.nib = 4'h2;
      5'b10101: d.nib = 4'h3;
      5'b01010: d.nib = 4'h4;
      5'b01011: d.nib = 4'h5;
      5'b01110: d.nib = 4'h6;
      5'b01111: d.nib = 4'h7;
      5'b10010: d.nib = 4'h8;
      5'b10011: d.nib = 4'h9;
      5'b10110: d.nib = 4'hA;
      5'b10111: d.nib = 4'hB;
      5'b11010: d.nib = 4'hC;
      5'b11011: d.nib = 4'hD;
      5'b11100: d.nib = 4'hE;
      5'b11101: d.nib = 4'hF;
      5'b11111, 5'b11000, 5'b10001,
      5'b01101, 5'b00111: d.kind = K_CTRL;
      5'b00100:           d.kind = K_HALT;
      default:            d.kind = K_INVALID;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sym_classify.sv
module sym_classify
  import sym_dec_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  output logic [NIB_W-1:0] nib,
  output sym_kind_e        kind
);
  dec_t res;

  always_comb begin
    res  = decode_sym(sym);
    nib  = res.nib;
    kind = res.kind;
  end
endmodule

// File: rtl/sym_err_counter.sv
module sym_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             frame_active,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);
  logic counted;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      counted <= 1'b0;
    end else begin
      if (!frame_active)
        counted <= 1'b0;
      else if (hit)
        counted <= 1'b1;

      if (clr)
        count <= '0;
      else if (hit && !counted)
        count <= count + CNT_W'(1);
    end
  end

  // R9: clear wins and yields zero
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R6: count moves by at most one per cycle (wrapping, R8)
  a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));

  // R6: once counted within a frame, no further increments
  a_r6_once_per_frame: assert property (@(posedge clk) disable iff (rst)
    (counted && frame_active && !clr) |=> (count == $past(count)));

  // R4: no increment without a hit
  a_r4_no_hit_no_count: assert property (@(posedge clk) disable iff (rst)
    (!hit && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/sym_out_stage.sv
module sym_out_stage
  import sym_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cg_valid,
  input  logic             frame_active,
  input  logic             raw_mode,
  input  logic [SYM_W-1:0] sym,
  input  logic [NIB_W-1:0] dec_nib,
  input  sym_kind_e        kind,
  output logic             out_valid,
  output logic [NIB_W-1:0] nib_out,
  output logic [SYM_W-1:0] raw_out,
  output logic             rx_err
);
  logic bad_sym;
  assign bad_sym = (kind == K_INVALID) || (kind == K_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      nib_out   <= '0;
      raw_out   <= '0;
      rx_err    <= 1'b0;
    end else begin
      out_valid <= cg_valid;
      if (cg_valid) begin
        if (raw_mode) begin
          nib_out <= sym[NIB_W-1:0];
          raw_out <= sym;
          rx_err  <= 1'b0;
        end else begin
          nib_out <= (kind == K_DATA) ? dec_nib : '0;
          raw_out <= '0;
          rx_err  <= frame_active && bad_sym;
        end
      end else begin
        rx_err <= 1'b0;
      end
    end
  end

  // R4: nothing flagged outside a frame
  a_r4_no_err_outside: assert property (@(posedge clk) disable iff (rst)
    (cg_valid && !frame_active) |=> !rx_err);

  // R10: bypass passes the symbol and never flags
  a_r10_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (cg_valid && raw_mode) |=> (!rx_err && raw_out == $past(sym)));

  // R12: idle cycle drops the strobe and the flag, holds the nibble
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !cg_valid |=> (!out_valid && !rx_err && $stable(nib_out)));
endmodule

// File: rtl/rx_symbol_decoder.sv
module rx_symbol_decoder
  import sym_dec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cg_valid,
  input  logic [4:0]       cg_in,
  input  logic             frame_active,
  input  logic             raw_mode,
  input  logic             cnt_clear,
  output logic             out_valid,
  output logic [3:0]       nib_out,
  output logic [4:0]       raw_out,
  output logic             rx_err,
  output logic [CNT_W-1:0] err_count
);
  logic [NIB_W-1:0] dec_nib;
  sym_kind_e        kind;
  logic             hit;

  sym_classify u_classify (
    .sym  (cg_in),
    .nib  (dec_nib),
    .kind (kind)
  );

  assign hit = cg_valid && frame_active && !raw_mode && (kind == K_INVALID);

  sym_err_counter #(.CNT_W(CNT_W)) u_counter (
    .clk          (clk),
    .rst          (rst),
    .clr          (cnt_clear),
    .frame_active (frame_active),
    .hit          (hit),
    .count        (err_count)
  );

  sym_out_stage u_out (
    .clk          (clk),
    .rst          (rst),
    .cg_valid     (cg_valid),
    .frame_active (frame_active),
    .raw_mode     (raw_mode),
    .sym          (cg_in),
    .dec_nib      (dec_nib),
    .kind         (kind),
    .out_valid    (out_valid),
    .nib_out      (nib_out),
    .raw_out      (raw_out),
    .rx_err       (rx_err)
  );

  // R5: halt symbol in a frame flags but does not count
  a_r5_halt_no_count: assert property (@(posedge clk) disable iff (rst)
    (cg_valid && frame_active && !raw_mode && !cnt_clear && cg_in == 5'b00100)
      |=> (rx_err && err_count == $past(err_count)));
endmodule

// File: tb/tb_rx_symbol_decoder.sv
module tb_rx_symbol_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cg_valid = 1'b0;
  logic [4:0]  cg_in = '0;
  logic        frame_active = 1'b0;
  logic        raw_mode = 1'b0;
  logic        cnt_clear = 1'b0;
  logic        out_valid;
  logic [3:0]  nib_out;
  logic [4:0]  raw_out;
  logic        rx_err;
  logic [15:0] err_count;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int exp_cnt = 0;

  logic [4:0] data_cg [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
  logic [4:0] ctrl_cg [5]  = '{5'b11111, 5'b11000, 5'b10001, 5'b01101, 5'b00111};
  logic [4:0] bad_cg  [10] = '{5'b00010, 5'b00011, 5'b00101, 5'b01000, 5'b01100,
                               5'b10000, 5'b00000, 5'b00001, 5'b00110, 5'b11001};

  rx_symbol_decoder dut (
    .clk(clk), .rst(rst), .cg_valid(cg_valid), .cg_in(cg_in),
    .frame_active(frame_active), .raw_mode(raw_mode), .cnt_clear(cnt_clear),
    .out_valid(out_valid), .nib_out(nib_out), .raw_out(raw_out),
    .rx_err(rx_err), .err_count(err_count)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input int act, input int exp, input string req);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic step(input logic v, input logic [4:0] s, input logic fa,
                      input logic byp, input logic clr);
    cg_valid = v; cg_in = s; frame_active = fa; raw_mode = byp; cnt_clear = clr;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(out_valid, 0, "R11 out_valid");
    chk(rx_err, 0, "R11 rx_err");
    chk(nib_out, 0, "R11 nib_out");
    chk(raw_out, 0, "R11 raw_out");
    chk(err_count, 0, "R11 err_count");
  endtask

  task automatic t_data;
    for (int i = 0; i < 16; i++) begin
      step(1, data_cg[i], 1, 0, 0);
      chk(nib_out, i, "R1 nibble");
      chk(out_valid, 1, "R1 out_valid");
      chk(rx_err, 0, "R1 no error");
    end
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_ctrl;
    for (int i = 0; i < 5; i++) begin
      step(1, ctrl_cg[i], 1, 0, 0);
      chk(nib_out, 0, "R2 ctrl nibble");
      chk(rx_err, 0, "R2 ctrl no error");
    end
    chk(err_count, exp_cnt, "R2 count untouched");
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_invalid;
    for (int i = 0; i < 10; i++) begin
      step(1, bad_cg[i], 1, 0, 0);
      chk(rx_err, 1, "R3 invalid flagged");
      chk(nib_out, 0, "R3 invalid nibble");
    end
    exp_cnt = exp_cnt + 1;
    chk(err_count, exp_cnt, "R6 once per frame");
    step(0, 0, 0, 0, 0);
    step(1, 5'b00010, 1, 0, 0);
    exp_cnt = exp_cnt + 1;
    chk(err_count, exp_cnt, "R7 new frame counts");
    step(1, 5'b01000, 1, 0, 0);
    chk(err_count, exp_cnt, "R6 second error same frame");
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_outside;
    for (int i = 0; i < 10; i++) begin
      step(1, bad_cg[i], 0, 0, 0);
      chk(rx_err, 0, "R4 no flag outside frame");
    end
    step(1, 5'b00100, 0, 0, 0);
    chk(rx_err, 0, "R4 halt outside frame");
    chk(err_count, exp_cnt, "R4 no count outside frame");
  endtask

  task automatic t_halt;
    step(1, 5'b00100, 1, 0, 0);
    chk(rx_err, 1, "R5 halt flagged");
    chk(nib_out, 0, "R5 halt nibble");
    chk(err_count, exp_cnt, "R5 halt not counted");
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_bypass;
    step(1, 5'b10011, 1, 1, 0);
    chk(raw_out, 5'b10011, "R10 raw symbol");
    chk(nib_out, 4'b0011, "R10 raw low bits");
    chk(rx_err, 0, "R10 no flag");
    step(1, 5'b00010, 1, 1, 0);
    chk(raw_out, 5'b00010, "R10 raw invalid passed");
    chk(rx_err, 0, "R10 invalid not flagged");
    chk(err_count, exp_cnt, "R10 invalid not counted");
    step(1, 5'b11110, 1, 0, 0);
    chk(raw_out, 0, "R10 raw_out zero when decoding");
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_idle;
    step(1, data_cg[9], 1, 0, 0);
    step(1, 5'b00101, 1, 0, 0);
    step(1, data_cg[7], 1, 0, 0);
    step(0, 5'b00101, 1, 0, 0);
    chk(out_valid, 0, "R12 out_valid low");
    chk(rx_err, 0, "R12 rx_err low");
    chk(nib_out, 7, "R12 nibble held");
    exp_cnt = exp_cnt + 1;
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_clear;
    chk(err_count, exp_cnt, "R9 precondition");
    step(1, 5'b00011, 1, 0, 1);
    exp_cnt = 0;
    chk(err_count, 0, "R9 clear beats increment");
    step(0, 0, 0, 0, 0);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 65535; i++) begin
      step(1, 5'b10000, 1, 0, 0);
      step(0, 0, 0, 0, 0);
    end
    chk(err_count, 16'hFFFF, "R8 reaches max");
    step(1, 5'b10000, 1, 0, 0);
    chk(err_count, 0, "R8 wraps to zero");
    step(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_data();
    t_ctrl();
    t_invalid();
    t_outside();
    t_halt();
    t_bypass();
    t_idle();
    t_clear();
    t_wrap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule